// File: doc/BRIEF.md
# Abort Exception Entry Controller

This block handles abort exceptions in a small 32-bit pipelined core. A fault flag from instruction fetch travels with each fetched instruction through a decode stage and an execute stage that the block holds. A fault reported on a data access arrives directly from the memory interface, together with the address of the instruction that made the access. A faulting fetch does not start an exception when it is reported. The tagged instruction is only marked as not executable. If an older instruction flushes it before it reaches execute, nothing happens. If it reaches execute, the abort is entered at that point.

Entry takes one cycle. In that cycle the block clears the younger stages and drops the instruction being fetched. On the next clock edge it presents a one-cycle `exc_taken` strobe together with the values the core writes when the strobe is high:
- the return address for the abort-mode link register;
- the status word to save;
- the new status word;
- the fetch redirect target.

A data abort belongs to an older instruction than the one in execute. So when both are pending, the data abort wins and the tagged instruction is discarded.

Top module: `abort_entry_ctrl`

## Requirements
- R1: An instruction fetched with `if_fault`=0 appears on `ex_issue` in the second cycle after it is fetched. An instruction fetched with `if_fault`=1 never asserts `ex_issue`.
- R2: A tagged instruction raises no exception while it is in decode or on its first cycle in execute. The strobe `exc_taken` rises on the clock edge that ends the instruction's execute cycle.
- R3: A tagged instruction that a `flush` removes, either in decode or in the cycle it sits in execute, never causes `exc_taken`.
- R4: `link_addr` equals the address of the tagged instruction plus 4 on a prefetch abort, and `mem_pc` plus 8 on a data abort.
- R5: `saved_status` equals `status_in` from the detection cycle. `new_status` equals that word with bits [4:0] forced to 5'b10111, the interrupt mask bit 7 set, and bits [31:8], 6 and 5 unchanged.
- R6: `exc_code` is 2'b01 and `redirect_pc` is 32'h0000000C for a prefetch abort. They are 2'b10 and 32'h00000010 for a data abort. `exc_code` is 2'b00 whenever `exc_taken` is low.
- R7: `exc_taken` is high for exactly one cycle per entry and is never high in two consecutive cycles. A `mem_fault` that is held for two cycles gives a single entry.
- R8: When `mem_fault` and a tagged instruction in execute occur in the same cycle, the data abort is taken. The tagged instruction is discarded and raises no later exception.
- R9: After reset, `exc_taken`, `ex_issue` and `exc_code` are 0.
- R10: At entry, the instruction in decode is flushed. Any instruction fetched in the detection cycle or in the `exc_taken` cycle is also dropped, so none of them issues or aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | A fetched instruction is present |
| if_pc | input | 32 | Address of the fetched instruction |
| if_fault | input | 1 | The fetch of this instruction faulted |
| flush | input | 1 | An older instruction kills the decode and execute stages |
| mem_fault | input | 1 | The memory interface reports a data access fault |
| mem_pc | input | 32 | Address of the instruction whose data access faulted |
| status_in | input | 32 | Current status register |
| ex_issue | output | 1 | The instruction in execute may execute |
| exc_taken | output | 1 | One-cycle abort entry strobe, also the write enable for the outputs below |
| exc_code | output | 2 | 01 prefetch abort, 10 data abort, 00 none |
| link_addr | output | 32 | Value for the abort-mode link register |
| saved_status | output | 32 | Value for the abort-mode saved status register |
| new_status | output | 32 | New status register value |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
A data fault and a fetch-tagged instruction in execute can fall in the same cycle. The bench provokes this by fetching a tagged instruction, waiting two cycles until it sits in execute, and then raising `mem_fault` with a different address. The result is judged by the data-abort code, the data-abort link value and the data-abort vector on the strobe, and by the absence of any second strobe in the following cycles. A separate case checks a flush against a tagged instruction in execute.

// File: rtl/abort_entry_ctrl.sv
module abort_entry_ctrl #(
  parameter logic [31:0] PABT_VEC  = 32'h0000_000C,
  parameter logic [31:0] DABT_VEC  = 32'h0000_0010,
  parameter logic [4:0]  ABT_MODE  = 5'b10111,
  parameter int          IMASK_BIT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        if_valid,
  input  logic [31:0] if_pc,
  input  logic        if_fault,
  input  logic        flush,
  input  logic        mem_fault,
  input  logic [31:0] mem_pc,
  input  logic [31:0] status_in,
  output logic        ex_issue,
  output logic        exc_taken,
  output logic [1:0]  exc_code,
  output logic [31:0] link_addr,
  output logic [31:0] saved_status,
  output logic [31:0] new_status,
  output logic [31:0] redirect_pc
);
  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_PABT = 2'b01;
  localparam logic [1:0] CODE_DABT = 2'b10;

  logic        id_v, id_fault, ex_v, ex_fault;
  logic [31:0] id_pc, ex_pc;
  logic        take_d, take_p, kill;
  logic [31:0] status_abt;

  assign take_d   = mem_fault & ~exc_taken;
  assign take_p   = ex_v & ex_fault & ~flush & ~mem_fault & ~exc_taken;
  assign kill     = flush | take_d | take_p | exc_taken;
  assign ex_issue = ex_v & ~ex_fault & ~flush & ~mem_fault & ~exc_taken;

  always_comb begin
    status_abt            = status_in;
    status_abt[IMASK_BIT] = 1'b1;
    status_abt[4:0]       = ABT_MODE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_v     <= 1'b0;
      id_fault <= 1'b0;
      id_pc    <= '0;
      ex_v     <= 1'b0;
      ex_fault <= 1'b0;
      ex_pc    <= '0;
    end else begin
      id_v     <= if_valid & ~kill;
      id_fault <= if_fault;
      id_pc    <= if_pc;
      ex_v     <= id_v & ~kill;
      ex_fault <= id_fault;
      ex_pc    <= id_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_taken    <= 1'b0;
      exc_code     <= CODE_NONE;
      link_addr    <= '0;
      saved_status <= '0;
      new_status   <= '0;
      redirect_pc  <= '0;
    end else begin
      exc_taken <= take_d | take_p;
      exc_code  <= take_d ? CODE_DABT : (take_p ? CODE_PABT : CODE_NONE);
      if (take_d | take_p) begin
        link_addr    <= take_d ? mem_pc + 32'd8 : ex_pc + 32'd4;
        saved_status <= status_in;
        new_status   <= status_abt;
        redirect_pc  <= take_d ? DABT_VEC : PABT_VEC;
      end
    end
  end

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> !exc_taken);

  assert_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (new_status[4:0] == ABT_MODE && new_status[IMASK_BIT]
                   && new_status[31:8] == saved_status[31:8]));

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> ((exc_code == CODE_DABT && redirect_pc == DABT_VEC) ||
                   (exc_code == CODE_PABT && redirect_pc == PABT_VEC)));

  assert_data_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fault && !exc_taken) |=> (exc_taken && exc_code == CODE_DABT));

  assert_flush_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !mem_fault) |=> (!exc_taken && !ex_issue));

  assert_code_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> exc_code == CODE_NONE);
endmodule

// File: tb/sim_abort_entry_ctrl.sv
`timescale 1ns/1ps
module sim_abort_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_valid, if_fault, flush, mem_fault;
  logic [31:0] if_pc, mem_pc, status_in;
  logic        ex_issue, exc_taken;
  logic [1:0]  exc_code;
  logic [31:0] link_addr, saved_status, new_status, redirect_pc;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  abort_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_fault(if_fault), .flush(flush), .mem_fault(mem_fault),
    .mem_pc(mem_pc), .status_in(status_in), .ex_issue(ex_issue),
    .exc_taken(exc_taken), .exc_code(exc_code), .link_addr(link_addr),
    .saved_status(saved_status), .new_status(new_status),
    .redirect_pc(redirect_pc)
  );

  function automatic logic [31:0] exp_status(input logic [31:0] s);
    return {s[31:8], 1'b1, s[6:5], 5'b10111};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    if_valid = 0; if_fault = 0; if_pc = '0; flush = 0; mem_fault = 0; mem_pc = '0;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic tag);
    if_valid = 1; if_pc = pc; if_fault = tag;
  endtask

  task automatic t_reset();
    idle(); status_in = 32'h0; rst_n = 0;
    step(); step();
    check(exc_taken == 0, "R9 exc_taken", exc_taken, 0);
    check(ex_issue == 0, "R9 ex_issue", ex_issue, 0);
    check(exc_code == 0, "R9 exc_code", exc_code, 0);
    rst_n = 1; step();
  endtask

  task automatic t_clean();
    fetch(32'h40, 0); step();
    idle(); check(ex_issue == 0, "R1 clean in decode", ex_issue, 0);
    step(); check(ex_issue == 1, "R1 clean issues", ex_issue, 1);
    step(); check(exc_taken == 0, "R1 clean no abort", exc_taken, 0);
    check(exc_code == 2'b00, "R6 code idle", exc_code, 0);
  endtask

  task automatic t_prefetch();
    status_in = 32'hF000_0053;
    fetch(32'h100, 1); step();
    idle(); check(exc_taken == 0, "R2 not at decode", exc_taken, 0);
    step();
    check(ex_issue == 0, "R1 tagged not issued", ex_issue, 0);
    check(exc_taken == 0, "R2 not immediate", exc_taken, 0);
    step();
    check(exc_taken == 1, "R2 taken at execute", exc_taken, 1);
    check(exc_code == 2'b01, "R6 prefetch code", exc_code, 2'b01);
    check(redirect_pc == 32'h0C, "R6 prefetch vector", redirect_pc, 32'h0C);
    check(link_addr == 32'h104, "R4 prefetch link", link_addr, 32'h104);
    check(saved_status == 32'hF000_0053, "R5 saved", saved_status, 32'hF000_0053);
    check(new_status == exp_status(32'hF000_0053), "R5 new status", new_status,
          exp_status(32'hF000_0053));
    step();
    check(exc_taken == 0, "R7 one pulse", exc_taken, 0);
  endtask

  task automatic t_data();
    status_in = 32'h2000_0010;
    mem_fault = 1; mem_pc = 32'h800; step();
    idle();
    check(exc_taken == 1, "R6 data taken", exc_taken, 1);
    check(exc_code == 2'b10, "R6 data code", exc_code, 2'b10);
    check(redirect_pc == 32'h10, "R6 data vector", redirect_pc, 32'h10);
    check(link_addr == 32'h808, "R4 data link", link_addr, 32'h808);
    check(new_status == exp_status(32'h2000_0010), "R5 data new status",
          new_status, exp_status(32'h2000_0010));
    step(); check(exc_taken == 0, "R7 data one pulse", exc_taken, 0);
  endtask

  task automatic t_held();
    mem_fault = 1; mem_pc = 32'h900; step();
    check(exc_taken == 1, "R7 held first", exc_taken, 1);
    step();
    check(exc_taken == 0, "R7 held no repeat", exc_taken, 0);
    idle(); step();
    check(exc_taken == 0, "R7 held quiet", exc_taken, 0);
  endtask

  task automatic t_flush_decode();
    fetch(32'h200, 1); step();
    idle(); flush = 1; step();
    flush = 0; check(ex_issue == 0, "R3 flushed decode", ex_issue, 0);
    step(); check(exc_taken == 0, "R3 flushed decode no abort", exc_taken, 0);
    step(); check(exc_taken == 0, "R3 flushed decode quiet", exc_taken, 0);
  endtask

  task automatic t_flush_execute();
    fetch(32'h240, 1); step();
    idle(); step();
    flush = 1; step();
    flush = 0; check(exc_taken == 0, "R3 flushed execute", exc_taken, 0);
    step(); check(exc_taken == 0, "R3 flushed execute quiet", exc_taken, 0);
  endtask

  task automatic t_both();
    fetch(32'h300, 1); step();
    idle(); step();
    mem_fault = 1; mem_pc = 32'h200; step();
    idle();
    check(exc_taken == 1, "R8 taken", exc_taken, 1);
    check(exc_code == 2'b10, "R8 data wins", exc_code, 2'b10);
    check(link_addr == 32'h208, "R8 data link", link_addr, 32'h208);
    check(redirect_pc == 32'h10, "R8 data vector", redirect_pc, 32'h10);
    step(); check(exc_taken == 0, "R8 tag discarded", exc_taken, 0);
    step(); check(exc_taken == 0, "R8 tag discarded later", exc_taken, 0);
  endtask

  task automatic t_younger();
    fetch(32'h500, 0); step();
    fetch(32'h504, 0); mem_fault = 1; mem_pc = 32'h4FC; step();
    fetch(32'h508, 1); mem_fault = 0;
    check(exc_taken == 1, "R10 entry", exc_taken, 1);
    step();
    idle(); check(ex_issue == 0, "R10 decode flushed", ex_issue, 0);
    step(); check(ex_issue == 0, "R10 fetch dropped", ex_issue, 0);
    check(exc_taken == 0, "R10 no abort from dropped", exc_taken, 0);
    step(); check(exc_taken == 0, "R10 quiet", exc_taken, 0);
    check(ex_issue == 0, "R10 still empty", ex_issue, 0);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_prefetch();
    t_data();
    t_held();
    t_flush_decode();
    t_flush_execute();
    t_both();
    t_younger();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule